// File: doc/BRIEF.md
# Descriptor-Driven Configuration Transfer Engine

This block is a bus-master engine that moves bytes between system memory and a keyed configuration item store. Software builds a 16-byte descriptor in memory, then writes the descriptor's 64-bit physical address into the engine's address register. The write that completes the address starts a job. The engine fetches the descriptor byte by byte and decodes its control word. It can select a new item and then reads, writes or skips the requested number of bytes against the current item.

Completion is reported only through memory. The engine overwrites the descriptor's control word with zero on success or with the error value on failure. A read of the register window returns a fixed 8-byte identification tag, so software can probe for the engine. The item store lives outside the block and is shared with another access port. The engine drives the key and the byte offset, and the store returns the item length, a writable flag and the byte at that offset.

Top module: `cfg_dma_engine`

## Requirements
- R1: Writes to the address register take effect only as follows. A 4-byte write at offset 0 sets the upper 32 address bits and does not start a job. A 4-byte write at offset 4 sets the lower 32 bits and starts a job. An 8-byte write at offset 0 sets all 64 bits and starts a job. Writes of any other size or offset are ignored.
- R2: A register read with byte count 1, 2, 4 or 8 at offset A, where A plus the count is at most 8, returns bytes A onwards of the tag 0x51454D5520434647, taken most significant byte first and right-aligned. Any other read returns zero.
- R3: A job first reads 16 single bytes at descriptor address +0 to +15. These hold, big-endian, a 32-bit control word, a 32-bit length and a 64-bit memory address. The control word uses bit 1 for read, bit 2 for skip, bit 3 for select, bit 4 for write, and bits 31:16 for the key.
- R4: When the select bit is set, the key is taken from control bits 31:16 and the item offset returns to 0 before any byte moves. Without the select bit, the key and offset left by the previous job stay in use.
- R5: When several operation bits are set, read wins over write, and write wins over skip. With none set, no data moves and the status written back is zero.
- R6: A read copies item bytes from the current offset into memory at ascending addresses, and the offset rises by one per byte. Once the offset reaches the item length (zero for an unknown key), each remaining byte is written to memory as 0x00 and the offset stays where it is.
- R7: A skip consumes the whole length without any memory access. The offset advances by one per byte but not past the item length.
- R8: A write copies memory bytes into the item at the current offset. A write to an item that is not writable, or at an offset at or beyond its length, ends the job with error status.
- R9: An error response on any transfer beat ends the job with error status, and bytes already moved stay moved. An error response during the descriptor fetch ends the job with no transfer and no selection.
- R10: Every job ends with four single-byte writes at descriptor address +0 to +3. They carry 00 00 00 00 on success and 00 00 00 01 on error.
- R11: The busy output is high from the cycle after the starting write until the last status write has completed. While busy is high, all address register writes are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 3 | Byte offset within the register window |
| regSize | input | 4 | Access size in bytes |
| regWrData | input | 64 | Write data, right-aligned |
| regRdData | output | 64 | Tag read data, right-aligned |
| busy | output | 1 | Job in progress |
| memReqValid | output | 1 | Memory request valid |
| memReqReady | input | 1 | Memory request accepted |
| memReqWrite | output | 1 | Request is a write |
| memReqAddr | output | 64 | Byte address |
| memReqWdata | output | 8 | Write byte |
| memRspValid | input | 1 | Response valid |
| memRspData | input | 8 | Read byte |
| memRspErr | input | 1 | Response carries a fault |
| itemKey | output | 16 | Selected item key |
| itemOffset | output | 32 | Current byte offset in the item |
| itemLen | input | 32 | Length of the keyed item, 0 if absent |
| itemWritable | input | 1 | Keyed item accepts writes |
| itemRdData | input | 8 | Item byte at the offset |
| itemWrEn | output | 1 | Item byte write strobe |
| itemWrData | output | 8 | Item byte to write |

## Verification
A corrupted descriptor shift register or byte counter shows up as a status word at the wrong address, or as a wrong byte count per job. Both are visible as soon as the job ends. A wrong key or offset register appears in the item bytes that land in memory on the next read job, and directly on the itemKey and itemOffset ports. A wrong error flag or wrong operation priority changes the written-back status or the target bytes of that same job. The bench therefore checks memory contents, the item store and the beat count after every job.

// File: rtl/cfg_dma_pkg.sv
package cfg_dma_pkg;
  // access kinds steer the address/data muxes in the datapath
  typedef enum logic [1:0] {AK_FETCH, AK_MEM_WR, AK_MEM_RD, AK_WBACK} accKind_t;
  typedef enum logic [1:0] {OP_NONE, OP_READ, OP_WRITE, OP_SKIP} op_t;

  typedef struct packed {
    logic clrCnt;
    logic incCnt;
    logic shiftDesc;
    logic loadJob;
    logic ldKey;
    logic incOffset;
    logic decLen;
    logic incAddr;
    logic setErr;
    logic clrErr;
  } strobe_t;

  // control word flag positions (fixed by the descriptor format)
  localparam int CtlRead  = 1;
  localparam int CtlSkip  = 2;
  localparam int CtlSel   = 3;
  localparam int CtlWrite = 4;

  localparam logic [63:0] IdTag = 64'h5145_4D55_2043_4647;
endpackage

// File: rtl/cfg_dma_dpath.sv
module cfg_dma_dpath
  import cfg_dma_pkg::*;
#(
  parameter int ADDR_W = 64,
  parameter int LEN_W  = 32,
  parameter int KEY_W  = 16,
  parameter int OFF_W  = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [2:0]        regAddr,
  input  logic [3:0]        regSize,
  input  logic [63:0]       regWrData,
  output logic [63:0]       regRdData,
  input  logic              busy,
  output logic              trigger,
  input  strobe_t           stb,
  input  accKind_t          accKind,
  output logic [ADDR_W-1:0] memReqAddr,
  output logic [7:0]        memReqWdata,
  input  logic [7:0]        memRspData,
  input  logic [OFF_W-1:0]  itemLen,
  input  logic [7:0]        itemRdData,
  output logic [KEY_W-1:0]  itemKey,
  output logic [OFF_W-1:0]  itemOffset,
  output logic [7:0]        itemWrData,
  output logic [3:0]        opBits,
  output logic              lenZero,
  output logic              exhausted,
  output logic              fetchLast,
  output logic              wbLast,
  output logic              errFlag
);
  localparam int CTL_W      = 32;
  localparam int DESC_W     = CTL_W + LEN_W + ADDR_W;
  localparam int DESC_BYTES = DESC_W / 8;
  localparam int CNT_W      = $clog2(DESC_BYTES + 1);
  localparam int LEN_LO     = ADDR_W;
  localparam int CTL_LO     = ADDR_W + LEN_W;
  localparam int WB_BYTES   = CTL_W / 8;

  logic [ADDR_W-1:0] descAddr;
  logic [DESC_W-1:0] desc;
  logic [CNT_W-1:0]  cnt;
  logic [LEN_W-1:0]  xferLen;
  logic [ADDR_W-1:0] memAddr;

  // register decode
  logic wrHi, wrLo, wrFull;
  assign wrHi    = regWrEn && regSize == 4'd4 && regAddr == 3'd0;
  assign wrLo    = regWrEn && regSize == 4'd4 && regAddr == 3'd4;
  assign wrFull  = regWrEn && regSize == 4'd8 && regAddr == 3'd0;
  assign trigger = !busy && (wrLo || wrFull);

  // tag read: bytes selected by offset and size, right-aligned
  always_comb begin
    int sz, ad;
    logic [63:0] mask;
    sz = int'(regSize);
    ad = int'(regAddr);
    regRdData = '0;
    mask = '1;
    if ((sz == 1 || sz == 2 || sz == 4 || sz == 8) && ad + sz <= 8) begin
      if (sz != 8) mask = (64'd1 << (sz * 8)) - 64'd1;
      regRdData = (IdTag >> ((8 - ad - sz) * 8)) & mask;
    end
  end

  assign opBits    = {desc[CTL_LO+CtlWrite], desc[CTL_LO+CtlSel],
                      desc[CTL_LO+CtlSkip], desc[CTL_LO+CtlRead]};
  assign lenZero   = xferLen == '0;
  assign exhausted = itemOffset >= itemLen;
  assign fetchLast = cnt == CNT_W'(DESC_BYTES - 1);
  assign wbLast    = cnt == CNT_W'(WB_BYTES - 1);
  assign itemWrData = memRspData;

  always_comb begin
    memReqAddr  = memAddr;
    memReqWdata = exhausted ? 8'h00 : itemRdData;
    unique case (accKind)
      AK_FETCH:  memReqAddr = descAddr + ADDR_W'(cnt);
      AK_WBACK: begin
        memReqAddr  = descAddr + ADDR_W'(cnt);
        memReqWdata = wbLast ? {7'd0, errFlag} : 8'h00;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      descAddr   <= '0;
      desc       <= '0;
      cnt        <= '0;
      xferLen    <= '0;
      memAddr    <= '0;
      itemKey    <= '0;
      itemOffset <= '0;
      errFlag    <= 1'b0;
    end else begin
      if (!busy) begin
        if (wrHi)   descAddr[ADDR_W-1:32] <= regWrData[ADDR_W-33:0];
        if (wrLo)   descAddr[31:0]        <= regWrData[31:0];
        if (wrFull) descAddr              <= regWrData[ADDR_W-1:0];
      end
      if (stb.clrCnt)      cnt <= '0;
      else if (stb.incCnt) cnt <= cnt + 1'b1;
      if (stb.shiftDesc) desc <= {desc[DESC_W-9:0], memRspData};
      if (stb.setErr)      errFlag <= 1'b1;
      else if (stb.clrErr) errFlag <= 1'b0;
      if (stb.loadJob) begin
        xferLen <= desc[LEN_LO +: LEN_W];
        memAddr <= desc[ADDR_W-1:0];
      end else begin
        if (stb.decLen)  xferLen <= xferLen - 1'b1;
        if (stb.incAddr) memAddr <= memAddr + 1'b1;
      end
      if (stb.ldKey) begin
        itemKey    <= desc[DESC_W-1 -: KEY_W];
        itemOffset <= '0;
      end else if (stb.incOffset) begin
        itemOffset <= itemOffset + 1'b1;
      end
    end
  end

  AST_REGS_FROZEN: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> $stable(descAddr)); // R11
  AST_OFFSET_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> itemOffset <= itemLen); // R6
endmodule

// File: rtl/cfg_dma_ctrl.sv
module cfg_dma_ctrl
  import cfg_dma_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     trigger,
  input  logic [3:0] opBits,
  input  logic     lenZero,
  input  logic     exhausted,
  input  logic     itemWritable,
  input  logic     fetchLast,
  input  logic     wbLast,
  input  logic     errFlag,
  input  logic     memReqReady,
  input  logic     memRspValid,
  input  logic     memRspErr,
  output strobe_t  stb,
  output accKind_t accKind,
  output logic     memReqValid,
  output logic     memReqWrite,
  output logic     itemWrEn,
  output logic     busy
);
  typedef enum logic [3:0] {
    S_IDLE, S_FETCH_REQ, S_FETCH_RSP, S_DECODE, S_XFER,
    S_MEM_REQ, S_MEM_RSP, S_WB_REQ, S_WB_RSP
  } state_t;

  state_t state, nxt;
  op_t    op, decOp;

  // priority: read, then write, then skip
  always_comb begin
    if (opBits[0])      decOp = OP_READ;
    else if (opBits[3]) decOp = OP_WRITE;
    else if (opBits[1]) decOp = OP_SKIP;
    else                decOp = OP_NONE;
  end

  always_comb begin
    nxt = state;
    stb = '0;
    accKind = AK_FETCH;
    memReqValid = 1'b0;
    memReqWrite = 1'b0;
    itemWrEn = 1'b0;
    unique case (state)
      S_IDLE: if (trigger) begin
        stb.clrCnt = 1'b1;
        stb.clrErr = 1'b1;
        nxt = S_FETCH_REQ;
      end
      S_FETCH_REQ: begin
        memReqValid = 1'b1;
        if (memReqReady) nxt = S_FETCH_RSP;
      end
      S_FETCH_RSP: if (memRspValid) begin
        if (memRspErr) begin
          stb.setErr = 1'b1;
          stb.clrCnt = 1'b1;
          nxt = S_WB_REQ;
        end else begin
          stb.shiftDesc = 1'b1;
          stb.incCnt = 1'b1;
          nxt = fetchLast ? S_DECODE : S_FETCH_REQ;
        end
      end
      S_DECODE: begin
        stb.loadJob = 1'b1;
        stb.ldKey = opBits[2];
        stb.clrCnt = 1'b1;
        nxt = (decOp == OP_NONE) ? S_WB_REQ : S_XFER;
      end
      S_XFER: begin
        if (lenZero) nxt = S_WB_REQ;
        else begin
          unique case (op)
            OP_WRITE: if (exhausted || !itemWritable) begin
              stb.setErr = 1'b1;
              nxt = S_WB_REQ;
            end else nxt = S_MEM_REQ;
            OP_SKIP: begin
              stb.decLen = 1'b1;
              stb.incOffset = !exhausted;
            end
            default: nxt = S_MEM_REQ;
          endcase
        end
      end
      S_MEM_REQ: begin
        memReqValid = 1'b1;
        memReqWrite = (op == OP_READ);
        accKind = (op == OP_READ) ? AK_MEM_WR : AK_MEM_RD;
        if (memReqReady) nxt = S_MEM_RSP;
      end
      S_MEM_RSP: begin
        accKind = (op == OP_READ) ? AK_MEM_WR : AK_MEM_RD;
        if (memRspValid) begin
          if (memRspErr) begin
            stb.setErr = 1'b1;
            nxt = S_WB_REQ;
          end else begin
            stb.decLen = 1'b1;
            stb.incAddr = 1'b1;
            stb.incOffset = !exhausted;
            itemWrEn = (op == OP_WRITE);
            nxt = S_XFER;
          end
        end
      end
      S_WB_REQ: begin
        accKind = AK_WBACK;
        memReqValid = 1'b1;
        memReqWrite = 1'b1;
        if (memReqReady) nxt = S_WB_RSP;
      end
      S_WB_RSP: begin
        accKind = AK_WBACK;
        if (memRspValid) begin
          stb.incCnt = 1'b1;
          nxt = wbLast ? S_IDLE : S_WB_REQ;
        end
      end
      default: nxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= S_IDLE;
      op <= OP_NONE;
    end else begin
      state <= nxt;
      if (state == S_DECODE) op <= decOp;
    end
  end

  assign busy = state != S_IDLE;

  AST_WR_ALLOWED: assert property (@(posedge clk) disable iff (!rstN)
    itemWrEn |-> itemWritable && !exhausted); // R8
  AST_DONE_LEN: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_WB_REQ && $past(state) == S_XFER && !errFlag) |-> lenZero); // R7
endmodule

// File: rtl/cfg_dma_engine.sv
module cfg_dma_engine
  import cfg_dma_pkg::*;
#(
  parameter int ADDR_W = 64,
  parameter int LEN_W  = 32,
  parameter int KEY_W  = 16,
  parameter int OFF_W  = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [2:0]        regAddr,
  input  logic [3:0]        regSize,
  input  logic [63:0]       regWrData,
  output logic [63:0]       regRdData,
  output logic              busy,
  output logic              memReqValid,
  input  logic              memReqReady,
  output logic              memReqWrite,
  output logic [ADDR_W-1:0] memReqAddr,
  output logic [7:0]        memReqWdata,
  input  logic              memRspValid,
  input  logic [7:0]        memRspData,
  input  logic              memRspErr,
  output logic [KEY_W-1:0]  itemKey,
  output logic [OFF_W-1:0]  itemOffset,
  input  logic [OFF_W-1:0]  itemLen,
  input  logic              itemWritable,
  input  logic [7:0]        itemRdData,
  output logic              itemWrEn,
  output logic [7:0]        itemWrData
);
  strobe_t  stb;
  accKind_t accKind;
  logic trigger, lenZero, exhausted, fetchLast, wbLast, errFlag;
  logic [3:0] opBits;

  cfg_dma_ctrl u_ctrl (
    .clk, .rstN, .trigger, .opBits, .lenZero, .exhausted, .itemWritable,
    .fetchLast, .wbLast, .errFlag, .memReqReady, .memRspValid, .memRspErr,
    .stb, .accKind, .memReqValid, .memReqWrite, .itemWrEn, .busy
  );

  cfg_dma_dpath #(
    .ADDR_W(ADDR_W), .LEN_W(LEN_W), .KEY_W(KEY_W), .OFF_W(OFF_W)
  ) u_dpath (
    .clk, .rstN, .regWrEn, .regAddr, .regSize, .regWrData, .regRdData,
    .busy, .trigger, .stb, .accKind, .memReqAddr, .memReqWdata, .memRspData,
    .itemLen, .itemRdData, .itemKey, .itemOffset, .itemWrData, .opBits,
    .lenZero, .exhausted, .fetchLast, .wbLast, .errFlag
  );

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid && !memReqReady |=> memReqValid && $stable(memReqAddr)
      && $stable(memReqWrite)); // R3
  AST_NO_REQ_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !memReqValid && !itemWrEn); // R11
endmodule

// File: tb/cfg_dma_engine_bench.sv
`timescale 1ns/1ps
module cfg_dma_engine_bench;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #2.5 clk = ~clk;

  logic regWrEn = 1'b0;
  logic [2:0] regAddr = '0;
  logic [3:0] regSize = '0;
  logic [63:0] regWrData = '0;
  logic [63:0] regRdData;
  logic busy, memReqValid, memReqReady, memReqWrite, memRspValid, memRspErr;
  logic [63:0] memReqAddr;
  logic [7:0] memReqWdata, memRspData, itemRdData, itemWrData;
  logic [15:0] itemKey;
  logic [31:0] itemOffset, itemLen;
  logic itemWritable, itemWrEn;

  cfg_dma_engine u_cfg_dma_engine (
    .clk, .rstN, .regWrEn, .regAddr, .regSize, .regWrData, .regRdData, .busy,
    .memReqValid, .memReqReady, .memReqWrite, .memReqAddr, .memReqWdata,
    .memRspValid, .memRspData, .memRspErr, .itemKey, .itemOffset, .itemLen,
    .itemWritable, .itemRdData, .itemWrEn, .itemWrData
  );

  // memory model: 256 bytes by low address bits, fault window 0xE0..0xEF
  logic [7:0] mem [256];
  logic [7:0] itemData [32];
  logic rspV = 1'b0, stallTog = 1'b0;
  logic tbWrEn = 1'b0, clrReq = 1'b0;
  logic [7:0] tbWrAddr = '0, tbWrData = '0;
  int reqCount = 0;
  logic [63:0] firstAddr = '0;

  assign memReqReady = !rspV && stallTog;
  assign memRspValid = rspV;

  always @(posedge clk) begin
    if (!rstN) begin
      rspV <= 1'b0;
      stallTog <= 1'b0;
      for (int i = 0; i < 256; i++) mem[i] <= 8'h00;
      for (int i = 0; i < 32; i++) itemData[i] <= 8'h00;
      for (int i = 0; i < 5; i++) itemData[i] <= 8'h10 + 8'(i);
      for (int i = 0; i < 8; i++) itemData[8+i] <= 8'h40 + 8'(i);
    end else begin
      stallTog <= ~stallTog;
      if (rspV) rspV <= 1'b0;
      if (tbWrEn) mem[tbWrAddr] <= tbWrData;
      if (clrReq) reqCount <= 0;
      if (memReqValid && memReqReady) begin
        rspV <= 1'b1;
        memRspErr <= memReqAddr[7:4] == 4'hE;
        memRspData <= mem[memReqAddr[7:0]];
        if (memReqWrite && memReqAddr[7:4] != 4'hE) mem[memReqAddr[7:0]] <= memReqWdata;
        if (reqCount == 0 && !clrReq) firstAddr <= memReqAddr;
        if (!clrReq) reqCount <= reqCount + 1;
      end
      if (itemWrEn) itemData[{itemKey[1:0], itemOffset[2:0]}] <= itemWrData;
    end
  end

  // item store: key0 len5 read-only, key1 len8 writable, others absent
  always_comb begin
    itemLen = 32'd0;
    if (itemKey == 16'd0) itemLen = 32'd5;
    if (itemKey == 16'd1) itemLen = 32'd8;
  end
  assign itemWritable = itemKey == 16'd1;
  assign itemRdData = (itemKey < 16'd4 && itemOffset < 32'd8)
                      ? itemData[{itemKey[1:0], itemOffset[2:0]}] : 8'h00;

  int checks = 0, failures = 0;
  localparam logic [7:0] SigB [8] = '{8'h51, 8'h45, 8'h4D, 8'h55, 8'h20, 8'h43, 8'h46, 8'h47};
  localparam logic [31:0] SEL = 32'h08, RD = 32'h02, SKP = 32'h04, WR = 32'h10;

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic poke(logic [7:0] a, logic [7:0] d);
    @(negedge clk); tbWrEn = 1'b1; tbWrAddr = a; tbWrData = d;
    @(negedge clk); tbWrEn = 1'b0;
  endtask

  task automatic putDesc(logic [7:0] base, logic [31:0] ctl, logic [31:0] len, logic [63:0] addr);
    logic [127:0] d;
    d = {ctl, len, addr};
    for (int i = 0; i < 16; i++) poke(base + 8'(i), d[127 - 8*i -: 8]);
  endtask

  task automatic regWrite(logic [2:0] a, logic [3:0] sz, logic [63:0] d);
    @(negedge clk); regWrEn = 1'b1; regAddr = a; regSize = sz; regWrData = d;
    @(negedge clk); regWrEn = 1'b0;
  endtask

  task automatic waitIdle();
    for (int i = 0; i < 4000; i++) begin
      if (!busy) break;
      @(negedge clk);
    end
  endtask

  task automatic clearCount();
    @(negedge clk); clrReq = 1'b1;
    @(negedge clk); clrReq = 1'b0;
  endtask

  task automatic runJob(logic [7:0] base);
    clearCount();
    regWrite(3'd4, 4'd4, {56'd0, base});
    waitIdle();
  endtask

  function automatic logic [31:0] stat(logic [7:0] base);
    return {mem[base], mem[base+8'd1], mem[base+8'd2], mem[base+8'd3]};
  endfunction

  initial begin
    #(5.0 * 150000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk("R11 reset busy", busy, 0);
    chk("R11 reset no request", memReqValid, 0);
    chk("R4 reset offset", itemOffset, 0);

    // R2 tag sweep
    for (int a = 0; a < 8; a++) begin
      for (int s = 1; s <= 8; s = s * 2) begin
        logic [63:0] exp;
        exp = '0;
        if (a + s <= 8) for (int k = 0; k < s; k++) exp = (exp << 8) | 64'(SigB[a+k]);
        @(negedge clk); regAddr = 3'(a); regSize = 4'(s);
        #1 chk($sformatf("R2 tag read a=%0d s=%0d", a, s), regRdData, exp);
      end
    end
    @(negedge clk); regAddr = 3'd0; regSize = 4'd3;
    #1 chk("R2 odd size read", regRdData, 0);

    // R3 R4 R6 R10: select key0, read 3
    putDesc(8'h00, SEL | RD, 3, 64'h80);
    runJob(8'h00);
    chk("R6 read bytes", {mem[8'h80], mem[8'h81], mem[8'h82]}, 24'h101112);
    chk("R10 success status", stat(8'h00), 0);
    chk("R3 beat count", reqCount, 16 + 3 + 4);

    // R4 R6: continue without select, runs past end
    putDesc(8'h10, RD, 4, 64'h88);
    runJob(8'h10);
    chk("R6 read past end zero fill", {mem[8'h88], mem[8'h89], mem[8'h8A], mem[8'h8B]}, 32'h13140000);
    chk("R6 offset stops at length", itemOffset, 5);

    // R7 skip then read
    putDesc(8'h20, SEL | SKP, 2, 64'h0);
    runJob(8'h20);
    chk("R7 skip no memory beats", reqCount, 20);
    chk("R7 skip offset", itemOffset, 2);
    putDesc(8'h30, RD, 2, 64'h90);
    runJob(8'h30);
    chk("R7 read after skip", {mem[8'h90], mem[8'h91]}, 16'h1213);

    // R8 write into writable item
    poke(8'hA0, 8'hA5); poke(8'hA1, 8'h5A); poke(8'hA2, 8'h3C);
    putDesc(8'h40, (32'd1 << 16) | SEL | WR, 3, 64'hA0);
    runJob(8'h40);
    chk("R8 write data", {itemData[8], itemData[9], itemData[10]}, 24'hA55A3C);
    chk("R8 write status", stat(8'h40), 0);

    // R8 write read-only item
    putDesc(8'h50, SEL | WR, 2, 64'hA0);
    runJob(8'h50);
    chk("R8 read-only error", stat(8'h50), 1);
    chk("R8 read-only unchanged", itemData[0], 8'h10);

    // R8 write past end
    putDesc(8'h60, (32'd1 << 16) | SEL | SKP, 8, 64'h0);
    runJob(8'h60);
    putDesc(8'h70, WR, 1, 64'hA0);
    runJob(8'h70);
    chk("R8 write past end error", stat(8'h70), 1);
    chk("R8 write past end beats", reqCount, 20);

    // R5 priority
    putDesc(8'h00, SEL | RD | WR | SKP, 1, 64'hB0);
    runJob(8'h00);
    chk("R5 read wins", mem[8'hB0], 8'h10);
    chk("R5 read wins status", stat(8'h00), 0);
    poke(8'hA3, 8'h77);
    putDesc(8'h10, (32'd1 << 16) | SEL | WR | SKP, 1, 64'hA3);
    runJob(8'h10);
    chk("R5 write over skip", itemData[8], 8'h77);
    putDesc(8'h20, SEL, 4, 64'hB8);
    runJob(8'h20);
    chk("R5 no op status", stat(8'h20), 0);
    chk("R5 no op beats", reqCount, 20);
    chk("R4 select without op", {itemKey, itemOffset[15:0]}, 32'h0);

    // R9 fault mid transfer
    putDesc(8'h30, (32'd1 << 16) | SEL | RD, 3, 64'hDF);
    runJob(8'h30);
    chk("R9 byte before fault", mem[8'hDF], 8'h77);
    chk("R9 fault status", stat(8'h30), 1);
    chk("R9 offset after fault", itemOffset, 1);
    // R9 fetch fault
    runJob(8'hE0);
    chk("R9 fetch fault beats", reqCount, 5);
    chk("R9 fetch fault no transfer", {itemKey, itemOffset[15:0]}, {16'd1, 16'd1});

    // R1 register decode
    putDesc(8'h40, 0, 0, 64'h0);
    regWrite(3'd0, 4'd4, 64'h1);
    chk("R1 high half no start", busy, 0);
    runJob(8'h40);
    chk("R1 high half used", firstAddr, 64'h1_0000_0040);
    regWrite(3'd0, 4'd4, 64'h0);
    putDesc(8'h50, 0, 0, 64'h0);
    clearCount();
    regWrite(3'd0, 4'd8, 64'h50);
    chk("R1 full write starts", busy, 1);
    waitIdle();
    chk("R1 full write address", firstAddr, 64'h50);
    regWrite(3'd0, 4'd2, 64'h40);
    chk("R1 two-byte write ignored", busy, 0);
    regWrite(3'd4, 4'd2, 64'h40);
    chk("R1 two-byte at 4 ignored", busy, 0);

    // R11 writes ignored while busy
    putDesc(8'h60, SEL | RD, 2, 64'hC0);
    putDesc(8'h70, (32'd1 << 16) | SEL | RD, 1, 64'hC8);
    clearCount();
    regWrite(3'd4, 4'd4, 64'h60);
    chk("R11 busy after start", busy, 1);
    regWrite(3'd4, 4'd4, 64'h70);
    waitIdle();
    chk("R11 first job data", {mem[8'hC0], mem[8'hC1]}, 16'h1011);
    chk("R11 second write ignored", mem[8'hC8], 8'h00);
    chk("R11 beat count", reqCount, 22);
    chk("R11 other descriptor untouched", stat(8'h70), (32'd1 << 16) | SEL | RD);
    @(negedge clk);
    chk("R11 idle after job", busy, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule